// File: doc/BRIEF.md
# Standard-Definition Video Line Timing Generator

This block produces the horizontal timing of one interlaced standard-definition video line. It runs from a 27 MHz clock at twice the pixel rate, so each clock carries one multiplexed chroma or luma sample. A line holds 1440 active sample slots followed by blanking. The total length is 1728 clocks for the 625-line standard and 1716 clocks for the 525-line standard. The outputs are the line position, an active-video flag, the Cb/Y/Cr/Y component phase, and a horizontal sync pulse whose delay can be set from zero to three clocks.

Three ways of running are supported. As timing master the line counter runs freely. In the two follower modes the counter stops at the last count of the line and stays in blanking. It starts a new line only when a sync event arrives. In external-sync follower mode the event is a rising edge on an external horizontal sync input. In embedded-sync follower mode the event is an end-of-active-video timing reference found in an incoming 8-bit component byte stream. That decoder also keeps the field and vertical-blanking bits of the last accepted reference.

Top module: `vid_line_timer`

## Requirements
- R1: The line position counts up by one per clock from 0. After 1727 (625-line, `std625_i`=1) or 1715 (525-line) it returns to 0 in master mode, which is `run_mode_i`=0 (the value 3 also acts as master).
- R2: `active_o` is 1 exactly when the line position is between 0 and 1439. It is 0 during all blanking, including any follower hold.
- R3: `phase_o` equals the line position modulo 4, with 0=Cb, 1=Y, 2=Cr and 3=Y, so position 0 carries Cb.
- R4: The undelayed horizontal sync is high for 127 clocks. It starts at position 1464 in 625-line mode and at position 1472 in 525-line mode.
- R5: `hsync_o` is the undelayed horizontal sync delayed by `hdel_i` clocks (0 to 3). With `hdel_i`=0 the path has no register.
- R6: In external-sync follower mode (`run_mode_i`=1) the position stays at the last count of the line. At the first clock edge where `ext_hsync_i` is sampled high after being low, the position becomes 0.
- R7: In embedded-sync follower mode (`run_mode_i`=2) the position stays at the last count until the bytes FF, 00, 00 on consecutive clocks are followed by a byte with bit 4 set. At the edge that samples that fourth byte the position becomes 0. A fourth byte with bit 4 clear, which is a start-of-active reference, does not restart the line.
- R8: On each accepted reference, `ref_field_o` takes bit 6 and `ref_vblank_o` takes bit 5 of the fourth byte. Both hold their value until the next accepted reference.
- R9: Changes to `std625_i` and `run_mode_i` are taken in only at the last count of a line. The current line keeps its length and its mode.
- R10: While reset is high, the position equals the last count of the selected standard, and `active_o`, `hsync_o`, `ref_field_o` and `ref_vblank_o` are 0.
- R11: A sync event that arrives while a follower-mode line is still counting has no effect on the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rst | input | 1 | Synchronous active-high reset |
| std625_i | input | 1 | 1 = 625-line standard, 0 = 525-line |
| run_mode_i | input | 2 | 0 master, 1 external-sync follower, 2 embedded-sync follower |
| hdel_i | input | 2 | Horizontal sync output delay in clocks |
| ext_hsync_i | input | 1 | External horizontal sync, rising edge used |
| data_i | input | 8 | Incoming component byte stream |
| line_pos_o | output | 11 | Current line position |
| active_o | output | 1 | Active-video flag |
| phase_o | output | 2 | Component phase of the current sample slot |
| hsync_o | output | 1 | Delayed horizontal sync |
| ref_field_o | output | 1 | Field bit of the last accepted reference |
| ref_vblank_o | output | 1 | Vertical-blanking bit of the last accepted reference |

## Verification
A wrong count or a wrong wrap point is visible on `line_pos_o` in the clock where it happens. It also moves the next `active_o` rise and the sync window, so the error shows up again on `active_o` and `hsync_o`. A follower that fails to hold, restarts on a start-of-active code, or reacts to a pulse in mid-line leaves the position off by one line within a few clocks. A mode or standard taken in mid-line changes the length of the line in progress and is caught before that line ends. A bad delay tap shifts `hsync_o` by whole clocks, which shows on its first edge.

// File: rtl/vlt_pkg.sv
package vlt_pkg;
    localparam int CNT_W          = 11;
    localparam int ACT_SAMPLES    = 1440;
    localparam int LINE_625       = 1728;
    localparam int LINE_525       = 1716;
    localparam int SYNC_START_625 = 1464;
    localparam int SYNC_START_525 = 1472;
    localparam int SYNC_WIDTH     = 127;
    localparam int MAX_DLY        = 3;
    localparam int PRE_LEN        = 3;

    typedef logic [CNT_W-1:0] pos_t;

    typedef enum logic [1:0] {
        RUN_MASTER = 2'd0,
        RUN_EXT    = 2'd1,
        RUN_EMB    = 2'd2,
        RUN_SPARE  = 2'd3
    } run_mode_e;

    typedef enum logic [1:0] {
        PH_CB = 2'd0,
        PH_Y0 = 2'd1,
        PH_CR = 2'd2,
        PH_Y1 = 2'd3
    } comp_phase_e;

    typedef struct packed {
        logic hit;
        logic fld;
        logic vbl;
    } ref_evt_t;

    function automatic pos_t line_last(input logic std625);
        return std625 ? pos_t'(LINE_625 - 1) : pos_t'(LINE_525 - 1);
    endfunction

    function automatic pos_t sync_first(input logic std625);
        return std625 ? pos_t'(SYNC_START_625) : pos_t'(SYNC_START_525);
    endfunction
endpackage

// File: rtl/vlt_ref_decode.sv
module vlt_ref_decode
    import vlt_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] byte_i,
    output ref_evt_t          evt_o
);
    localparam logic [BYTE_W-1:0] ALL_ONES = {BYTE_W{1'b1}};

    logic [BYTE_W-1:0] hist [PRE_LEN];
    logic [PRE_LEN-1:0] stage_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PRE_LEN; i++) hist[i] <= '0;
        end else begin
            hist[0] <= byte_i;
            for (int i = 1; i < PRE_LEN; i++) hist[i] <= hist[i-1];
        end
    end

    // oldest stage must be all ones, the younger ones all zeros
    for (genvar g = 0; g < PRE_LEN; g++) begin : g_stage
        if (g == PRE_LEN - 1) begin : g_ones
            assign stage_ok[g] = (hist[g] == ALL_ONES);
        end else begin : g_zero
            assign stage_ok[g] = (hist[g] == '0);
        end
    end

    always_comb begin
        evt_o.hit = (&stage_ok) & byte_i[4];
        evt_o.fld = byte_i[6];
        evt_o.vbl = byte_i[5];
    end

    // R7: a start-of-active code (bit 4 clear) never yields an event
    p_sav_reject_r7: assert property (@(posedge clk) disable iff (rst)
        !byte_i[4] |-> !evt_o.hit);
endmodule

// File: rtl/vlt_line_counter.sv
module vlt_line_counter
    import vlt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      std625_i,
    input  run_mode_e mode_i,
    input  logic      ext_hs_i,
    input  ref_evt_t  ref_i,
    output pos_t      pos_o,
    output logic      std_q_o
);
    pos_t      pos_q;
    logic      std_q;
    run_mode_e mode_q;
    logic      ext_q;
    logic      ext_rise;
    logic      at_end;
    logic      restart;

    assign ext_rise = ext_hs_i & ~ext_q;
    assign at_end   = (pos_q == line_last(std_q));

    always_comb begin
        unique case (mode_q)
            RUN_EXT: restart = ext_rise;
            RUN_EMB: restart = ref_i.hit;
            default: restart = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            std_q  <= std625_i;
            mode_q <= mode_i;
            pos_q  <= line_last(std625_i);
            ext_q  <= 1'b0;
        end else begin
            ext_q <= ext_hs_i;
            if (at_end) begin
                std_q  <= std625_i;
                mode_q <= mode_i;
                pos_q  <= restart ? '0 : line_last(std625_i);
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    assign pos_o   = pos_q;
    assign std_q_o = std_q;

    // R1: position never passes the last count of the latched standard
    p_range_r1: assert property (@(posedge clk) disable iff (rst)
        pos_q <= line_last(std_q));
    // R1: inside a line the count advances by one
    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        !at_end |=> pos_q == $past(pos_q) + 1'b1);
    // R1: master mode wraps at the line end
    p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (at_end && mode_q == RUN_MASTER) |=> pos_q == '0);
    // R6: external follower holds until a rising sync edge
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (at_end && mode_q == RUN_EXT && !ext_rise && std625_i == std_q) |=> $stable(pos_q));
    // R9: mode and standard stay fixed during a line
    p_latch_r9: assert property (@(posedge clk) disable iff (rst)
        !at_end |=> ($stable(std_q) && $stable(mode_q)));
endmodule

// File: rtl/vlt_sync_delay.sv
module vlt_sync_delay
    import vlt_pkg::*;
#(
    parameter int DEPTH = MAX_DLY
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       nom_i,
    input  logic [$clog2(DEPTH+1)-1:0] sel_i,
    output logic                       hs_o
);
    logic [DEPTH-1:0] dly_q;
    logic [DEPTH:0]   taps;

    always_ff @(posedge clk) begin
        if (rst) dly_q <= '0;
        else     dly_q <= {dly_q[DEPTH-2:0], nom_i};
    end

    assign taps = {dly_q, nom_i};
    assign hs_o = taps[sel_i];

    // R5: one-clock setting reproduces the previous nominal value
    p_one_clk_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && sel_i == 1) |-> hs_o == $past(nom_i));
endmodule

// File: rtl/vid_line_timer.sv
module vid_line_timer
    import vlt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        std625_i,
    input  logic [1:0]  run_mode_i,
    input  logic [1:0]  hdel_i,
    input  logic        ext_hsync_i,
    input  logic [7:0]  data_i,
    output logic [10:0] line_pos_o,
    output logic        active_o,
    output logic [1:0]  phase_o,
    output logic        hsync_o,
    output logic        ref_field_o,
    output logic        ref_vblank_o
);
    ref_evt_t    ref_evt;
    pos_t        pos;
    logic        std_q;
    logic        nom_hs;
    pos_t        hs_begin;
    comp_phase_e phase;
    logic        fld_q, vbl_q;

    vlt_ref_decode #(.BYTE_W(8)) u_dec (
        .clk   (clk),
        .rst   (rst),
        .byte_i(data_i),
        .evt_o (ref_evt)
    );

    vlt_line_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .std625_i(std625_i),
        .mode_i  (run_mode_e'(run_mode_i)),
        .ext_hs_i(ext_hsync_i),
        .ref_i   (ref_evt),
        .pos_o   (pos),
        .std_q_o (std_q)
    );

    assign hs_begin = sync_first(std_q);
    assign nom_hs   = (pos >= hs_begin) && (pos < hs_begin + pos_t'(SYNC_WIDTH));

    vlt_sync_delay #(.DEPTH(MAX_DLY)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .nom_i(nom_hs),
        .sel_i(hdel_i),
        .hs_o (hsync_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fld_q <= 1'b0;
            vbl_q <= 1'b0;
        end else if (ref_evt.hit) begin
            fld_q <= ref_evt.fld;
            vbl_q <= ref_evt.vbl;
        end
    end

    assign phase        = comp_phase_e'(pos[1:0]);
    assign line_pos_o   = pos;
    assign active_o     = (pos < pos_t'(ACT_SAMPLES));
    assign phase_o      = phase;
    assign ref_field_o  = fld_q;
    assign ref_vblank_o = vbl_q;

    // R2: active video always begins at position 0
    p_active_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(active_o) |-> line_pos_o == '0);
    // R3: the first active slot carries Cb
    p_first_cb_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(active_o) |-> phase == PH_CB);
    // R8: flags move only on an accepted reference
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !ref_evt.hit |=> ($stable(ref_field_o) && $stable(ref_vblank_o)));
endmodule

// File: tb/vid_line_timer_test.sv
module vid_line_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        std625_i = 1'b1;
    logic [1:0]  run_mode_i = 2'd0;
    logic [1:0]  hdel_i = 2'd0;
    logic        ext_hsync_i = 1'b0;
    logic [7:0]  data_i = 8'h00;
    logic [10:0] line_pos_o;
    logic        active_o;
    logic [1:0]  phase_o;
    logic        hsync_o;
    logic        ref_field_o;
    logic        ref_vblank_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    vid_line_timer uut (
        .clk(clk), .rst(rst), .std625_i(std625_i), .run_mode_i(run_mode_i),
        .hdel_i(hdel_i), .ext_hsync_i(ext_hsync_i), .data_i(data_i),
        .line_pos_o(line_pos_o), .active_o(active_o), .phase_o(phase_o),
        .hsync_o(hsync_o), .ref_field_o(ref_field_o), .ref_vblank_o(ref_vblank_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    int m_cnt, m_std, m_mode, m_prev_ext, m_fld, m_vbl;
    int m_bytes[$];
    int m_nom[$];
    bit m_valid = 0;

    function automatic int last_of(int s);
        return s ? 1727 : 1715;
    endfunction

    function automatic int nom_of(int c, int s);
        int b = s ? 1464 : 1472;
        return (c >= b && c < b + 127) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_std = std625_i; m_mode = run_mode_i;
            m_cnt = last_of(m_std);
            m_prev_ext = 0; m_fld = 0; m_vbl = 0;
            m_bytes = '{0, 0, 0};
            m_nom = '{0, 0, 0};
            m_valid = 1;
        end else begin
            int evt, rise, go;
            evt = (m_bytes[2] == 8'hFF && m_bytes[1] == 0 && m_bytes[0] == 0 && data_i[4]) ? 1 : 0;
            rise = (ext_hsync_i && !m_prev_ext) ? 1 : 0;
            m_nom.push_front(nom_of(m_cnt, m_std));
            void'(m_nom.pop_back());
            if (m_cnt == last_of(m_std)) begin
                if (m_mode == 1) go = rise;
                else if (m_mode == 2) go = evt;
                else go = 1;
                m_std = std625_i; m_mode = run_mode_i;
                m_cnt = go ? 0 : last_of(m_std);
            end else begin
                m_cnt = m_cnt + 1;
            end
            if (evt) begin m_fld = data_i[6]; m_vbl = data_i[5]; end
            m_prev_ext = ext_hsync_i;
            m_bytes.push_front(data_i);
            void'(m_bytes.pop_back());
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (m_valid && !done) begin
            int exp_hs;
            exp_hs = (hdel_i == 0) ? nom_of(m_cnt, m_std) : m_nom[hdel_i - 1];
            chk(line_pos_o == m_cnt, "R1", "line_pos", line_pos_o, m_cnt);
            chk(active_o == (m_cnt < 1440), "R2", "active", active_o, m_cnt < 1440);
            chk(phase_o == m_cnt % 4, "R3", "phase", phase_o, m_cnt % 4);
            chk(hsync_o == exp_hs, "R5", "hsync", hsync_o, exp_hs);
            chk(ref_field_o == m_fld, "R8", "field", ref_field_o, m_fld);
            chk(ref_vblank_o == m_vbl, "R8", "vblank", ref_vblank_o, m_vbl);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_pos(input int p);
        do @(negedge clk); while (line_pos_o != p);
    endtask

    task automatic wait_rise(output int at);
        bit prev;
        prev = active_o;
        forever begin
            @(negedge clk);
            if (active_o && !prev) break;
            prev = active_o;
        end
        at = cyc;
    endtask

    task automatic send_byte(input logic [7:0] b);
        data_i = b;
        step(1);
    endtask

    task automatic finish_run;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
        finish_run();
    end

    initial begin
        int t0, t1, hs_len, first_hs, max_pos, p;
        // R10: reset state
        step(3);
        @(negedge clk);
        chk(line_pos_o == 1727, "R10", "reset pos", line_pos_o, 1727);
        chk(!active_o && !hsync_o, "R10", "reset outputs", {active_o, hsync_o}, 0);
        chk(!ref_field_o && !ref_vblank_o, "R10", "reset flags", {ref_field_o, ref_vblank_o}, 0);
        @(posedge clk); #2;
        rst = 0;

        // R1: master 625 line period
        wait_rise(t0); wait_rise(t1);
        chk(t1 - t0 == 1728, "R1", "625 period", t1 - t0, 1728);

        // R4: sync window start and width with no delay
        hs_len = 0; first_hs = -1;
        while (line_pos_o != 1700) begin
            @(negedge clk);
            if (hsync_o) begin
                if (first_hs < 0) first_hs = line_pos_o;
                hs_len++;
            end
        end
        chk(first_hs == 1464, "R4", "625 sync start", first_hs, 1464);
        chk(hs_len == 127, "R4", "sync width", hs_len, 127);

        // R5: each delay setting over a line
        for (int d = 1; d < 4; d++) begin
            step(1);
            hdel_i = 2'(d);
            wait_pos(1600);
        end
        step(1);
        hdel_i = 2'd0;

        // R9: standard change in mid-line keeps the current line length
        wait_pos(500);
        step(1);
        std625_i = 1'b0;
        max_pos = 0;
        do begin
            @(negedge clk);
            if (line_pos_o > max_pos) max_pos = line_pos_o;
        end while (line_pos_o != 0);
        chk(max_pos == 1727, "R9", "line end after change", max_pos, 1727);
        wait_rise(t0); wait_rise(t1);
        chk(t1 - t0 == 1716, "R1", "525 period", t1 - t0, 1716);
        hs_len = 0; first_hs = -1;
        while (line_pos_o != 1700) begin
            @(negedge clk);
            if (hsync_o) begin
                if (first_hs < 0) first_hs = line_pos_o;
                hs_len++;
            end
        end
        chk(first_hs == 1472, "R4", "525 sync start", first_hs, 1472);

        // R6: external follower holds and restarts on a rising edge
        step(1);
        run_mode_i = 2'd1;
        std625_i = 1'b1;
        wait_pos(1715);
        step(1);
        wait_pos(1727);
        step(300);
        @(negedge clk);
        chk(line_pos_o == 1727, "R6", "hold pos", line_pos_o, 1727);
        chk(!active_o, "R2", "hold blank", active_o, 0);
        step(1);
        ext_hsync_i = 1'b1;
        step(1);
        @(negedge clk);
        chk(line_pos_o == 0, "R6", "restart pos", line_pos_o, 0);
        step(3);
        ext_hsync_i = 1'b0;

        // R11: mid-line pulse ignored
        wait_pos(100);
        p = line_pos_o;
        @(posedge clk); #2;
        ext_hsync_i = 1'b1;
        step(3);
        ext_hsync_i = 1'b0;
        @(negedge clk);
        chk(line_pos_o == p + 4, "R11", "mid-line pulse", line_pos_o, p + 4);

        // R7: embedded follower, start code ignored, end code restarts
        step(1);
        run_mode_i = 2'd2;
        wait_pos(1727);
        step(50);
        send_byte(8'hFF); send_byte(8'h00); send_byte(8'h00); send_byte(8'h80);
        send_byte(8'hFF); send_byte(8'h00); send_byte(8'hFF); send_byte(8'h00);
        send_byte(8'h00); send_byte(8'h00);
        @(negedge clk);
        chk(line_pos_o == 1727, "R7", "start code ignored", line_pos_o, 1727);
        send_byte(8'hFF); send_byte(8'h00); send_byte(8'h00); send_byte(8'hF0);
        @(negedge clk);
        chk(line_pos_o == 0, "R7", "end code restart", line_pos_o, 0);
        chk(ref_field_o && ref_vblank_o, "R8", "flags F0", {ref_field_o, ref_vblank_o}, 3);
        data_i = 8'h00;

        // R8: second reference with other flag values
        wait_pos(1727);
        step(10);
        send_byte(8'hFF); send_byte(8'h00); send_byte(8'h00); send_byte(8'hB0);
        @(negedge clk);
        chk(!ref_field_o && ref_vblank_o, "R8", "flags B0", {ref_field_o, ref_vblank_o}, 1);
        data_i = 8'h00;

        // R9: mode change in hold only; back to master
        step(1);
        run_mode_i = 2'd0;
        wait_pos(1727);
        step(3);
        @(negedge clk);
        chk(line_pos_o != 1727, "R9", "master resumes", line_pos_o, 0);
        wait_rise(t0); wait_rise(t1);
        chk(t1 - t0 == 1728, "R1", "master after follow", t1 - t0, 1728);
        step(5);
        finish_run();
    end
endmodule